// File: doc/BRIEF.md
# Burst-Read Memory Summation Accelerator

This block adds up a run of 32-bit words held in memory. Software programs a base byte address and a word count through a small AXI4-Lite register slave, then writes a start bit. The block fetches the data over an AXI4 read master in long incrementing bursts. Each burst is 512 words by default, which is 256 beats on a 64-bit data bus. The block adds both 32-bit lanes of every beat into one running total.

While a job runs, the block counts the clock cycles it spends. When the job ends it raises a done flag. Software then reads the sum, the cycle count and the flags. A data beat that returns a non-OKAY response sets a sticky error flag. The job still runs to the end. The block only issues full bursts, so software must give a word count that is a whole multiple of the burst length.

Top module: `burst_sum_accel`

## Requirements
- R1: After reset, all six register words read as zero, and the master has no read address or data handshake active (`m_ar_valid_o` = 0 and `m_r_ready_o` = 0).
- R2: The register map uses byte offsets:
  - 0x00: control.
  - 0x04: status.
  - 0x08: base address.
  - 0x0C: word count.
  - 0x10: sum.
  - 0x14: cycle count.

  Base and count are read/write, and each write byte lane is gated by its strobe bit. Status, sum and cycle count are read-only, and writes to them have no effect.
- R3: Each burst request uses these fields:
  - ARLEN = 255.
  - ARSIZE = 3.
  - ARBURST = 2'b01 (INCR).

  Burst n goes to base + n*2048. `m_ar_valid_o` and its address stay stable until the request is accepted.
- R4: The sum register holds the modulo-2^32 total of both 32-bit lanes of every beat received during the job.
- R5: The cycle counter is cleared on the clock that accepts the start write. It then increments on every following clock up to and including the clock that accepts the final beat, and holds its value afterwards.
- R6: Status bit 0 (done) reads 1 once the final beat of the last burst has been accepted.
- R7: Status bit 1 (error) is set by any beat whose RRESP is not 2'b00. The job still fetches all of its bursts, and the flag stays set until the next start.
- R8: A start write (control bit 0 = 1) made while a job is running is ignored. The job's burst count, sum and cycle count are unchanged.
- R9: An accepted start clears the sum, the cycle count, the done bit and the error bit.
- R10: The number of bursts is the word count divided by 512, with any remainder dropped. A count below 512 finishes at once: done is set, no burst is issued, and sum and cycle count stay at 0.
- R11: `m_r_ready_o` is high only while a burst's data is being received, and `m_ar_valid_o` is high only while a request is pending. The two are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| s_aw_addr_i | input | 6 | Lite write address (byte) |
| s_aw_valid_i | input | 1 | Lite write address valid |
| s_aw_ready_o | output | 1 | Lite write address ready |
| s_w_data_i | input | 32 | Lite write data |
| s_w_strb_i | input | 4 | Lite write byte strobes |
| s_w_valid_i | input | 1 | Lite write data valid |
| s_w_ready_o | output | 1 | Lite write data ready |
| s_b_resp_o | output | 2 | Lite write response (always OKAY) |
| s_b_valid_o | output | 1 | Lite write response valid |
| s_b_ready_i | input | 1 | Lite write response ready |
| s_ar_addr_i | input | 6 | Lite read address (byte) |
| s_ar_valid_i | input | 1 | Lite read address valid |
| s_ar_ready_o | output | 1 | Lite read address ready |
| s_r_data_o | output | 32 | Lite read data |
| s_r_resp_o | output | 2 | Lite read response (always OKAY) |
| s_r_valid_o | output | 1 | Lite read data valid |
| s_r_ready_i | input | 1 | Lite read data ready |
| m_ar_addr_o | output | 32 | Master burst address |
| m_ar_len_o | output | 8 | Master burst length minus one |
| m_ar_size_o | output | 3 | Master beat size code |
| m_ar_burst_o | output | 2 | Master burst type |
| m_ar_valid_o | output | 1 | Master address valid |
| m_ar_ready_i | input | 1 | Master address ready |
| m_r_data_i | input | 64 | Master read data |
| m_r_resp_i | input | 2 | Master read response |
| m_r_last_i | input | 1 | Master last beat of burst |
| m_r_valid_i | input | 1 | Master read data valid |
| m_r_ready_o | output | 1 | Master read data ready |

## Verification
Suppose the burst index or the address register is wrong. The next request then carries an address that disagrees with base + n*2048, and this shows at the very next address handshake. A request can also appear past the expected burst count, which the per-job burst tally catches when the job ends.

A lost or doubled lane, or a start that wrongly clears a running job, leaves a wrong sum at the sum register. This shows on the first read after done. A counter that starts on the wrong edge or keeps running after the final beat is off by one against the cycle count taken from the handshake edges. A re-read after an idle gap exposes any drift.

// File: rtl/burst_sum_pkg.sv
package burst_sum_pkg;
  typedef enum logic [1:0] {
    ST_IDLE      = 2'd0,
    ST_ISSUE_AR  = 2'd1,
    ST_RECV_DATA = 2'd2,
    ST_DONE      = 2'd3
  } rd_state_e;

  // register word indices (byte offset / 4)
  localparam logic [3:0] IDX_CTRL  = 4'd0;
  localparam logic [3:0] IDX_STAT  = 4'd1;
  localparam logic [3:0] IDX_BASE  = 4'd2;
  localparam logic [3:0] IDX_COUNT = 4'd3;
  localparam logic [3:0] IDX_SUM   = 4'd4;
  localparam logic [3:0] IDX_CYC   = 4'd5;

  localparam logic [1:0] RESP_OKAY  = 2'b00;
  localparam logic [1:0] BURST_INCR = 2'b01;
endpackage

// File: rtl/sum_lite_regs.sv
module sum_lite_regs
  import burst_sum_pkg::*;
#(
  parameter int REG_AW = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [REG_AW-1:0] s_aw_addr_i,
  input  logic              s_aw_valid_i,
  output logic              s_aw_ready_o,
  input  logic [31:0]       s_w_data_i,
  input  logic [3:0]        s_w_strb_i,
  input  logic              s_w_valid_i,
  output logic              s_w_ready_o,
  output logic [1:0]        s_b_resp_o,
  output logic              s_b_valid_o,
  input  logic              s_b_ready_i,
  input  logic [REG_AW-1:0] s_ar_addr_i,
  input  logic              s_ar_valid_i,
  output logic              s_ar_ready_o,
  output logic [31:0]       s_r_data_o,
  output logic [1:0]        s_r_resp_o,
  output logic              s_r_valid_o,
  input  logic              s_r_ready_i,
  output logic              start_o,
  output logic [31:0]       base_o,
  output logic [31:0]       count_o,
  input  logic [31:0]       sum_i,
  input  logic [31:0]       cycles_i,
  input  logic              done_i,
  input  logic              err_i
);
  localparam int IDX_W = REG_AW - 2;

  logic              b_valid_q, r_valid_q;
  logic [31:0]       rdata_q, rd_mux;
  logic [31:0]       base_q, count_q;
  logic              wr_en, rd_en;
  logic [IDX_W-1:0]  wr_idx, rd_idx;
  logic              unused_lo;

  assign unused_lo = ^{s_aw_addr_i[1:0], s_ar_addr_i[1:0]};

  assign wr_idx       = s_aw_addr_i[REG_AW-1:2];
  assign rd_idx       = s_ar_addr_i[REG_AW-1:2];
  assign wr_en        = s_aw_valid_i && s_w_valid_i && !b_valid_q;
  assign rd_en        = s_ar_valid_i && !r_valid_q;
  assign s_aw_ready_o = wr_en;
  assign s_w_ready_o  = wr_en;
  assign s_ar_ready_o = rd_en;
  assign s_b_valid_o  = b_valid_q;
  assign s_b_resp_o   = RESP_OKAY;
  assign s_r_valid_o  = r_valid_q;
  assign s_r_resp_o   = RESP_OKAY;
  assign s_r_data_o   = rdata_q;
  assign base_o       = base_q;
  assign count_o      = count_q;
  assign start_o      = wr_en && (wr_idx == IDX_W'(IDX_CTRL)) && s_w_strb_i[0] && s_w_data_i[0];

  always_comb begin
    rd_mux = '0;
    case (rd_idx)
      IDX_W'(IDX_STAT):  rd_mux = {30'd0, err_i, done_i};
      IDX_W'(IDX_BASE):  rd_mux = base_q;
      IDX_W'(IDX_COUNT): rd_mux = count_q;
      IDX_W'(IDX_SUM):   rd_mux = sum_i;
      IDX_W'(IDX_CYC):   rd_mux = cycles_i;
      default:           rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      b_valid_q <= 1'b0;
      base_q    <= '0;
      count_q   <= '0;
    end else begin
      if (wr_en) b_valid_q <= 1'b1;
      else if (s_b_ready_i) b_valid_q <= 1'b0;
      if (wr_en) begin
        for (int b = 0; b < 4; b++) begin
          if (s_w_strb_i[b]) begin
            if (wr_idx == IDX_W'(IDX_BASE))  base_q[8*b +: 8]  <= s_w_data_i[8*b +: 8];
            if (wr_idx == IDX_W'(IDX_COUNT)) count_q[8*b +: 8] <= s_w_data_i[8*b +: 8];
          end
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      r_valid_q <= 1'b0;
      rdata_q   <= '0;
    end else begin
      if (rd_en) begin
        r_valid_q <= 1'b1;
        rdata_q   <= rd_mux;
      end else if (s_r_ready_i) begin
        r_valid_q <= 1'b0;
      end
    end
  end

  assert_b_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s_b_valid_o && !s_b_ready_i |=> s_b_valid_o);
  assert_r_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s_r_valid_o && !s_r_ready_i |=> s_r_valid_o && $stable(s_r_data_o));
endmodule

// File: rtl/sum_burst_reader.sv
module sum_burst_reader
  import burst_sum_pkg::*;
#(
  parameter int DATA_W      = 64,
  parameter int BURST_WORDS = 512
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [31:0]       base_i,
  input  logic [31:0]       count_i,
  output logic [31:0]       m_ar_addr_o,
  output logic [7:0]        m_ar_len_o,
  output logic [2:0]        m_ar_size_o,
  output logic [1:0]        m_ar_burst_o,
  output logic              m_ar_valid_o,
  input  logic              m_ar_ready_i,
  input  logic [DATA_W-1:0] m_r_data_i,
  input  logic [1:0]        m_r_resp_i,
  input  logic              m_r_last_i,
  input  logic              m_r_valid_i,
  output logic              m_r_ready_o,
  output logic [31:0]       sum_o,
  output logic [31:0]       cycles_o,
  output logic              done_o,
  output logic              err_o
);
  localparam int LANES       = DATA_W / 32;
  localparam int BEATS       = BURST_WORDS / LANES;
  localparam int BURST_BYTES = BURST_WORDS * 4;
  localparam int BURST_SH    = $clog2(BURST_WORDS);
  localparam int SIZE_CODE   = $clog2(DATA_W / 8);

  rd_state_e   state_q;
  logic [31:0] addr_q, burst_idx_q, nburst_q, sum_q, cyc_q;
  logic [31:0] nburst_req, beat_sum;
  logic        err_q, last_burst, busy;

  logic [31:0] lane_acc [LANES+1];
  assign lane_acc[0] = '0;
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign lane_acc[l+1] = lane_acc[l] + m_r_data_i[32*l +: 32];
  end
  assign beat_sum = lane_acc[LANES];

  assign nburst_req   = count_i >> BURST_SH;
  assign last_burst   = (burst_idx_q == nburst_q - 32'd1);
  assign busy         = (state_q == ST_ISSUE_AR) || (state_q == ST_RECV_DATA);
  assign m_ar_addr_o  = addr_q;
  assign m_ar_len_o   = 8'(BEATS - 1);
  assign m_ar_size_o  = 3'(SIZE_CODE);
  assign m_ar_burst_o = BURST_INCR;
  assign m_ar_valid_o = (state_q == ST_ISSUE_AR);
  assign m_r_ready_o  = (state_q == ST_RECV_DATA);
  assign sum_o        = sum_q;
  assign cycles_o     = cyc_q;
  assign done_o       = (state_q == ST_DONE);
  assign err_o        = err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      addr_q      <= '0;
      burst_idx_q <= '0;
      nburst_q    <= '0;
      sum_q       <= '0;
      cyc_q       <= '0;
      err_q       <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE, ST_DONE: begin
          if (start_i) begin
            sum_q       <= '0;
            cyc_q       <= '0;
            err_q       <= 1'b0;
            burst_idx_q <= '0;
            nburst_q    <= nburst_req;
            addr_q      <= base_i;
            state_q     <= (nburst_req == '0) ? ST_DONE : ST_ISSUE_AR;
          end
        end
        ST_ISSUE_AR: begin
          cyc_q <= cyc_q + 32'd1;
          if (m_ar_ready_i) state_q <= ST_RECV_DATA;
        end
        ST_RECV_DATA: begin
          cyc_q <= cyc_q + 32'd1;
          if (m_r_valid_i) begin
            sum_q <= sum_q + beat_sum;
            if (m_r_resp_i != RESP_OKAY) err_q <= 1'b1;
            if (m_r_last_i) begin
              if (last_burst) begin
                state_q <= ST_DONE;
              end else begin
                burst_idx_q <= burst_idx_q + 32'd1;
                addr_q      <= addr_q + 32'(BURST_BYTES);
                state_q     <= ST_ISSUE_AR;
              end
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assert_ar_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    m_ar_valid_o && !m_ar_ready_i |=> m_ar_valid_o && $stable(m_ar_addr_o));
  assert_chan_excl_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(m_ar_valid_o && m_r_ready_o));
  assert_cyc_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !start_i |=> $stable(cycles_o) && $stable(sum_o));
  assert_busy_start_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy && start_i |=> cycles_o != '0);
  assert_err_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o && !start_i |=> err_o);
  assert_done_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    m_r_valid_i && m_r_ready_o && m_r_last_i && last_burst |=> done_o);
endmodule

// File: rtl/burst_sum_accel.sv
module burst_sum_accel #(
  parameter int REG_AW      = 6,
  parameter int DATA_W      = 64,
  parameter int BURST_WORDS = 512
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [REG_AW-1:0] s_aw_addr_i,
  input  logic              s_aw_valid_i,
  output logic              s_aw_ready_o,
  input  logic [31:0]       s_w_data_i,
  input  logic [3:0]        s_w_strb_i,
  input  logic              s_w_valid_i,
  output logic              s_w_ready_o,
  output logic [1:0]        s_b_resp_o,
  output logic              s_b_valid_o,
  input  logic              s_b_ready_i,
  input  logic [REG_AW-1:0] s_ar_addr_i,
  input  logic              s_ar_valid_i,
  output logic              s_ar_ready_o,
  output logic [31:0]       s_r_data_o,
  output logic [1:0]        s_r_resp_o,
  output logic              s_r_valid_o,
  input  logic              s_r_ready_i,
  output logic [31:0]       m_ar_addr_o,
  output logic [7:0]        m_ar_len_o,
  output logic [2:0]        m_ar_size_o,
  output logic [1:0]        m_ar_burst_o,
  output logic              m_ar_valid_o,
  input  logic              m_ar_ready_i,
  input  logic [DATA_W-1:0] m_r_data_i,
  input  logic [1:0]        m_r_resp_i,
  input  logic              m_r_last_i,
  input  logic              m_r_valid_i,
  output logic              m_r_ready_o
);
  logic        start, done, err;
  logic [31:0] base, count, sum, cycles;

  sum_lite_regs #(.REG_AW(REG_AW)) u_regs (
    .clk_i, .rst_ni,
    .s_aw_addr_i, .s_aw_valid_i, .s_aw_ready_o,
    .s_w_data_i, .s_w_strb_i, .s_w_valid_i, .s_w_ready_o,
    .s_b_resp_o, .s_b_valid_o, .s_b_ready_i,
    .s_ar_addr_i, .s_ar_valid_i, .s_ar_ready_o,
    .s_r_data_o, .s_r_resp_o, .s_r_valid_o, .s_r_ready_i,
    .start_o(start), .base_o(base), .count_o(count),
    .sum_i(sum), .cycles_i(cycles), .done_i(done), .err_i(err)
  );

  sum_burst_reader #(.DATA_W(DATA_W), .BURST_WORDS(BURST_WORDS)) u_reader (
    .clk_i, .rst_ni,
    .start_i(start), .base_i(base), .count_i(count),
    .m_ar_addr_o, .m_ar_len_o, .m_ar_size_o, .m_ar_burst_o,
    .m_ar_valid_o, .m_ar_ready_i,
    .m_r_data_i, .m_r_resp_i, .m_r_last_i, .m_r_valid_i, .m_r_ready_o,
    .sum_o(sum), .cycles_o(cycles), .done_o(done), .err_o(err)
  );
endmodule

// File: tb/burst_sum_accel_tb_top.sv
`timescale 1ns/1ps
module burst_sum_accel_tb_top;
  localparam int BEATS  = 256;
  localparam int BWORDS = 512;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [5:0]  aw_addr = '0, ar_addr = '0;
  logic        aw_valid = 0, w_valid = 0, ar_valid = 0;
  logic [31:0] w_data = '0;
  logic [3:0]  w_strb = '0;
  logic        s_aw_ready, s_w_ready, s_b_valid, s_ar_ready, s_r_valid;
  logic [1:0]  s_b_resp, s_r_resp;
  logic [31:0] s_r_data;
  logic [31:0] m_ar_addr;
  logic [7:0]  m_ar_len;
  logic [2:0]  m_ar_size;
  logic [1:0]  m_ar_burst;
  logic        m_ar_valid, m_r_ready;
  logic        m_ar_ready = 0, m_r_valid = 0, m_r_last = 0;
  logic [63:0] m_r_data = '0;
  logic [1:0]  m_r_resp = '0;

  burst_sum_accel dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .s_aw_addr_i(aw_addr), .s_aw_valid_i(aw_valid), .s_aw_ready_o(s_aw_ready),
    .s_w_data_i(w_data), .s_w_strb_i(w_strb), .s_w_valid_i(w_valid), .s_w_ready_o(s_w_ready),
    .s_b_resp_o(s_b_resp), .s_b_valid_o(s_b_valid), .s_b_ready_i(1'b1),
    .s_ar_addr_i(ar_addr), .s_ar_valid_i(ar_valid), .s_ar_ready_o(s_ar_ready),
    .s_r_data_o(s_r_data), .s_r_resp_o(s_r_resp), .s_r_valid_o(s_r_valid), .s_r_ready_i(1'b1),
    .m_ar_addr_o(m_ar_addr), .m_ar_len_o(m_ar_len), .m_ar_size_o(m_ar_size),
    .m_ar_burst_o(m_ar_burst), .m_ar_valid_o(m_ar_valid), .m_ar_ready_i(m_ar_ready),
    .m_r_data_i(m_r_data), .m_r_resp_i(m_r_resp), .m_r_last_i(m_r_last),
    .m_r_valid_i(m_r_valid), .m_r_ready_o(m_r_ready)
  );

  int n_chk = 0, n_fail = 0;
  int edge_cnt = 0;
  always @(posedge clk) edge_cnt <= edge_cnt + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] wf(input logic [31:0] a);
    return (a * 32'h0001_0003) ^ 32'h5A5A_1234;
  endfunction

  // memory model state
  logic [31:0] job_base = '0, bm_addr = '0, cap_addr = '0;
  logic [7:0]  cap_len = '0;
  logic [2:0]  cap_size = '0;
  logic [1:0]  cap_burst = '0;
  int  ar_cnt = 0, nb_exp = 0, bm_beat = 0, gbeat = 0, ar_wait = 0;
  int  inj_beat = -1, final_edge = 0;
  bit  bm_active = 0, ar_hs = 0, r_hs = 0, gap_en = 0, hold_data = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (ar_hs) begin
        chk(cap_addr == job_base + 32'(ar_cnt * 2048), "R3", "burst address", cap_addr,
            job_base + 32'(ar_cnt * 2048));
        chk(cap_len == 8'd255 && cap_size == 3'd3 && cap_burst == 2'b01, "R3", "len/size/burst",
            {19'd0, cap_len, cap_size, cap_burst}, {19'd0, 8'd255, 3'd3, 2'b01});
        bm_active = 1; bm_addr = cap_addr; bm_beat = 0; ar_cnt++; ar_wait = 0;
      end
      if (r_hs) begin
        bm_beat++; gbeat++;
        if (bm_beat == BEATS) bm_active = 0;
      end
      m_ar_ready = m_ar_valid && (ar_wait >= 2);
      if (m_ar_valid && !m_ar_ready) ar_wait++;
      m_r_valid  = bm_active && !hold_data && !(gap_en && (edge_cnt % 4 == 1));
      m_r_data   = {wf(bm_addr + 32'(8*bm_beat) + 32'd4), wf(bm_addr + 32'(8*bm_beat))};
      m_r_last   = (bm_beat == BEATS - 1);
      m_r_resp   = (gbeat == inj_beat) ? 2'b10 : 2'b00;
      ar_hs      = m_ar_valid && m_ar_ready;
      cap_addr = m_ar_addr; cap_len = m_ar_len; cap_size = m_ar_size; cap_burst = m_ar_burst;
      r_hs       = m_r_valid && m_r_ready;
      if (r_hs && m_r_last && ar_cnt == nb_exp) final_edge = edge_cnt + 1;
    end
  end

  task automatic lite_wr(input logic [5:0] a, input logic [31:0] d, input logic [3:0] s,
                         output int acc_edge);
    @(negedge clk);
    aw_addr = a; aw_valid = 1; w_data = d; w_strb = s; w_valid = 1;
    #1;
    while (!s_aw_ready) begin @(negedge clk); #1; end
    acc_edge = edge_cnt + 1;
    @(negedge clk);
    aw_valid = 0; w_valid = 0;
    while (!s_b_valid) @(negedge clk);
  endtask

  task automatic lite_rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    ar_addr = a; ar_valid = 1;
    #1;
    while (!s_ar_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    ar_valid = 0;
    while (!s_r_valid) @(negedge clk);
    d = s_r_data;
  endtask

  task automatic wait_done();
    logic [31:0] st;
    st = '0;
    for (int i = 0; i < 5000 && !st[0]; i++) lite_rd(6'h04, st);
  endtask

  function automatic logic [31:0] exp_sum(input logic [31:0] base, input int nb);
    logic [31:0] s;
    s = '0;
    for (int i = 0; i < nb * BWORDS; i++) s = s + wf(base + 32'(4*i));
    return s;
  endfunction

  task automatic arm(input logic [31:0] base, input logic [31:0] cnt, input bit gap, input int inj);
    int e;
    job_base = base; nb_exp = int'(cnt) / BWORDS; ar_cnt = 0; gbeat = 0;
    gap_en = gap; inj_beat = inj; final_edge = 0;
    lite_wr(6'h08, base, 4'hF, e);
    lite_wr(6'h0C, cnt, 4'hF, e);
  endtask

  task automatic check_end(input logic [31:0] base, input int start_edge, input bit exp_err);
    logic [31:0] v, c1;
    int ecyc;
    ecyc = (nb_exp == 0) ? 0 : final_edge - start_edge;
    lite_rd(6'h10, v);  chk(v == exp_sum(base, nb_exp), "R4", "sum", v, exp_sum(base, nb_exp));
    lite_rd(6'h14, c1); chk(c1 == 32'(ecyc), "R5", "cycle count", c1, 32'(ecyc));
    lite_rd(6'h04, v);  chk(v == {30'd0, exp_err, 1'b1}, "R6", "status done/err", v, {30'd0, exp_err, 1'b1});
    chk(ar_cnt == nb_exp, "R10", "burst count", 32'(ar_cnt), 32'(nb_exp));
    repeat (20) @(negedge clk);
    lite_rd(6'h14, v);  chk(v == c1, "R5", "cycle count holds", v, c1);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    for (int i = 0; i < 6; i++) begin
      lite_rd(6'(4*i), v);
      chk(v == '0, "R1", "reset register", v, '0);
    end
    chk(!m_ar_valid && !m_r_ready, "R1", "master idle", {30'd0, m_ar_valid, m_r_ready}, '0);
  endtask

  task automatic t_regs();
    logic [31:0] v;
    int e;
    lite_wr(6'h08, 32'h1234_5678, 4'hF, e);
    lite_wr(6'h08, 32'hAABB_CCDD, 4'b0100, e);
    lite_rd(6'h08, v); chk(v == 32'h12BB_5678, "R2", "base strobe write", v, 32'h12BB_5678);
    lite_wr(6'h0C, 32'h0000_0A00, 4'hF, e);
    lite_rd(6'h0C, v); chk(v == 32'h0000_0A00, "R2", "count readback", v, 32'h0000_0A00);
    lite_wr(6'h10, 32'hDEAD_BEEF, 4'hF, e);
    lite_wr(6'h14, 32'hDEAD_BEEF, 4'hF, e);
    lite_rd(6'h10, v); chk(v == '0, "R2", "sum read-only", v, '0);
    lite_rd(6'h14, v); chk(v == '0, "R2", "cycles read-only", v, '0);
  endtask

  task automatic t_job(input logic [31:0] base, input logic [31:0] cnt, input bit gap,
                       input int inj, input bit exp_err);
    int st;
    arm(base, cnt, gap, inj);
    lite_wr(6'h00, 32'h1, 4'h1, st);
    wait_done();
    check_end(base, st, exp_err);
  endtask

  task automatic t_clear_r9();
    logic [31:0] v;
    int st;
    hold_data = 1;
    arm(32'h0002_0000, 32'd512, 0, -1);
    lite_wr(6'h00, 32'h1, 4'h1, st);
    repeat (4) @(negedge clk);
    lite_rd(6'h10, v); chk(v == '0, "R9", "sum cleared by start", v, '0);
    lite_rd(6'h04, v); chk(v == '0, "R9", "done/err cleared by start", v, '0);
    hold_data = 0;
    wait_done();
    check_end(32'h0002_0000, st, 0);
  endtask

  task automatic t_busy_r8();
    int st, e;
    arm(32'h0004_0000, 32'd1024, 0, -1);
    lite_wr(6'h00, 32'h1, 4'h1, st);
    while (!(ar_cnt == 1 && bm_beat > 10)) @(negedge clk);
    lite_wr(6'h00, 32'h1, 4'h1, e);
    wait_done();
    chk(ar_cnt == 2, "R8", "bursts with ignored start", 32'(ar_cnt), 32'd2);
    check_end(32'h0004_0000, st, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_regs();
    t_job(32'h1000_0000, 32'd512, 0, -1, 0);     // R3 R4 R5 R6 single burst
    t_job(32'h0010_0000, 32'd1536, 1, -1, 0);    // R3 R4 gapped data, three bursts
    t_job(32'h0020_0000, 32'd1024, 1, 300, 1);   // R7 error mid job, all bursts still fetched
    t_clear_r9();                                // R9 R7 error cleared
    t_busy_r8();
    t_job(32'h0030_0000, 32'd0, 0, -1, 0);       // R10 zero count
    t_job(32'h0040_0000, 32'd700, 0, -1, 0);     // R10 remainder dropped
    chk(!m_ar_valid && !m_r_ready, "R11", "master idle after jobs", {30'd0, m_ar_valid, m_r_ready}, '0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule